// File: doc/BRIEF.md
# I2C Channel-Page Register Target

This block is a serial-bus target that holds the configuration bytes for four identical channels and one page shared by all of them. A host on an I2C or SMBus style two-wire bus, with SCL up to 400 kHz, addresses the block with a 7-bit target address. That address is built from two strap level codes. After the address, the host writes one pointer byte and then either writes data bytes or issues a repeated START and reads bytes back.

The top three bits of the pointer pick a window and the low five bits pick an offset inside a 32-byte page. Four windows reach one channel page each. Three broadcast windows send a single write to a group of channel pages, and a read from one of them returns one fixed channel's copy. The last window reaches the shared page. The pointer steps forward after every data byte and wraps within its offset bits. The block samples the bus on its own system clock and pulls SDA low through an open-drain enable.

Top module: `cfg_i2c_target`

## Requirements
- R1: With both strap codes in 0..3, the block acknowledges exactly the 7-bit address 0x18 + 8*strap_hi + 2*strap_lo (R/W in bit 0 of the address byte) and does not acknowledge any other address.
- R2: If either strap code is 4 or higher, the combination is reserved and no address is acknowledged.
- R3: The first byte written after the address is the pointer, with the window in bits 7:5 and the offset in bits 4:0. Each later data byte, written or read, goes to the pointer's location, and the pointer then advances. The offset wraps from 31 to 0 and the window bits do not change.
- R4: Windows 0, 1, 2 and 3 (pointer 0x00, 0x20, 0x40, 0x60) read and write the private page of channel 0, 1, 2 and 3 and touch no other page.
- R5: A write through window 4 (0x80) updates the offset in all four channel pages. A read through it returns channel 0's byte.
- R6: A write through window 5 (0xA0) updates channels 0 and 1 only. A read through it returns channel 0's byte.
- R7: A write through window 6 (0xC0) updates channels 2 and 3 only. A read through it returns channel 2's byte.
- R8: Window 7 (0xE0) reads and writes the shared page, which no channel window reaches.
- R9: A repeated START after the pointer byte begins a read at that pointer without an intervening STOP.
- R10: Reset clears every byte of all five pages to zero and releases SDA.
- R11: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP, clocked bytes are ignored until the next START. The block changes its SDA drive only while SCL is low.
- R12: When the host does not acknowledge a read byte, the block stops driving SDA and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low (open drain) |
| strap_hi | input | 3 | Upper strap level code; 0..3 valid, 4 and up reserved |
| strap_lo | input | 3 | Lower strap level code; 0..3 valid, 4 and up reserved |

## Verification
The hardest behaviour to observe from the ports is a broadcast read returning one specific channel's copy. After a broadcast write every copy holds the same byte, so the read result cannot tell which copy was returned. The stimulus therefore writes a broadcast value first. It then overwrites single channels through their private windows so that the copies differ, and only then reads through the broadcast window. In the same way, the offset wrap is driven with a burst that starts two bytes below the end of a page. Each stored byte is then read back through a different window, to show that the window bits did not move.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter logic [6:0] BASE_ADDR = 7'h18,
  parameter int         OFFS_W    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_hi,
  input  logic [2:0] strap_lo
);
  localparam int NPG   = 5;
  localparam int DEPTH = 1 << OFFS_W;
  localparam int WIN_W = 8 - OFFS_W;

  localparam logic [3:0] S_IDLE = 4'd0, S_ADDR = 4'd1, S_AACK = 4'd2,
                         S_PTR  = 4'd3, S_PACK = 4'd4, S_WDAT = 4'd5,
                         S_WACK = 4'd6, S_RDAT = 4'd7, S_RACK = 4'd8;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11;
      scl_q  <= 1'b1;  sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  wire       addr_ok = (strap_hi < 3'd4) && (strap_lo < 3'd4);
  wire [6:0] my_addr = BASE_ADDR + 7'({strap_hi[1:0], 3'b000})
                                 + 7'({strap_lo[1:0], 1'b0});

  logic [3:0] state, cnt;
  logic [7:0] sh, tx, ptr;
  logic       rw, mnack;

  wire [WIN_W-1:0]  win     = ptr[7:OFFS_W];
  wire [OFFS_W-1:0] off     = ptr[OFFS_W-1:0];
  wire [7:0]        ptr_inc = {win, off + 1'b1};

  logic [2:0]     rd_pg;
  logic [NPG-1:0] we_mask;

  always_comb begin
    case (win)
      3'd0:    begin rd_pg = 3'd0; we_mask = 5'b00001; end
      3'd1:    begin rd_pg = 3'd1; we_mask = 5'b00010; end
      3'd2:    begin rd_pg = 3'd2; we_mask = 5'b00100; end
      3'd3:    begin rd_pg = 3'd3; we_mask = 5'b01000; end
      3'd4:    begin rd_pg = 3'd0; we_mask = 5'b01111; end
      3'd5:    begin rd_pg = 3'd0; we_mask = 5'b00011; end
      3'd6:    begin rd_pg = 3'd2; we_mask = 5'b01100; end
      default: begin rd_pg = 3'd4; we_mask = 5'b10000; end
    endcase
  end

  wire            wr_stb = (state == S_WDAT) && scl_fall && (cnt == 4'd8);
  wire [NPG-1:0]  pg_we  = wr_stb ? we_mask : '0;

  logic [7:0] mem [NPG][DEPTH];
  wire  [7:0] rd_byte = mem[rd_pg][off];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int p = 0; p < NPG; p++)
        for (int o = 0; o < DEPTH; o++)
          mem[p][o] <= '0;
    end else begin
      for (int p = 0; p < NPG; p++)
        if (pg_we[p]) mem[p][off] <= sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mnack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (state == S_ADDR || state == S_PTR || state == S_WDAT) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      if (state == S_RDAT) cnt <= cnt + 4'd1;
      if (state == S_RACK) mnack <= sda_s;
    end else if (scl_fall) begin
      case (state)
        S_ADDR:
          if (cnt == 4'd8) begin
            if (addr_ok && sh[7:1] == my_addr) begin
              state  <= S_AACK;
              sda_oe <= 1'b1;
              rw     <= sh[0];
            end else begin
              state <= S_IDLE;
            end
          end
        S_AACK: begin
          cnt <= '0;
          if (rw) begin
            state  <= S_RDAT;
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
          end else begin
            state  <= S_PTR;
            sda_oe <= 1'b0;
          end
        end
        S_PTR:
          if (cnt == 4'd8) begin
            ptr    <= sh;
            sda_oe <= 1'b1;
            state  <= S_PACK;
          end
        S_PACK, S_WACK: begin
          state  <= S_WDAT;
          sda_oe <= 1'b0;
          cnt    <= '0;
        end
        S_WDAT:
          if (cnt == 4'd8) begin
            ptr    <= ptr_inc;
            sda_oe <= 1'b1;
            state  <= S_WACK;
          end
        S_RDAT:
          if (cnt == 4'd8) begin
            sda_oe <= 1'b0;
            ptr    <= ptr_inc;
            state  <= S_RACK;
          end else begin
            sda_oe <= ~tx[3'(4'd7 - cnt)];
          end
        S_RACK:
          if (!mnack) begin
            state  <= S_RDAT;
            tx     <= rd_byte;
            sda_oe <= ~rd_byte[7];
            cnt    <= '0;
          end else begin
            state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
endmodule

module cfg_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       sda_oe,
  input logic       start_det,
  input logic       in_addr,
  input logic       in_ptr,
  input logic       addr_ok,
  input logic [7:0] ptr,
  input logic [4:0] pg_we
);
  // R11
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !$past(scl_s));
  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);
  // R2
  reserved_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr && scl_fall && !addr_ok) |=> !sda_oe);
  // R3
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr[7:5] != $past(ptr[7:5])) |-> $past(in_ptr));
  // R8
  shared_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we[4] |-> (pg_we[3:0] == 4'b0000));
  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pg_we) |-> (!sda_oe && scl_fall));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .in_addr   (state == S_ADDR),
  .in_ptr    (state == S_PTR),
  .addr_ok   (addr_ok),
  .ptr       (ptr),
  .pg_we     (pg_we)
);

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [2:0] strap_hi = 3'd1;
  logic [2:0] strap_lo = 3'd2;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  cfg_i2c_target u_cfg_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_hi(strap_hi), .strap_lo(strap_lo));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int ref_mem [5][32];
  logic [7:0] m_ptr = 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ref_read(input logic [7:0] p);
    int w = int'(p[7:5]);
    int o = int'(p[4:0]);
    case (w)
      4, 5:    return ref_mem[0][o];
      6:       return ref_mem[2][o];
      7:       return ref_mem[4][o];
      default: return ref_mem[w][o];
    endcase
  endfunction

  task automatic ref_write(input logic [7:0] p, input logic [7:0] v);
    int w = int'(p[7:5]);
    int o = int'(p[4:0]);
    case (w)
      4: for (int c = 0; c < 4; c++) ref_mem[c][o] = v;
      5: for (int c = 0; c < 2; c++) ref_mem[c][o] = v;
      6: for (int c = 2; c < 4; c++) ref_mem[c][o] = v;
      7: ref_mem[4][o] = v;
      default: ref_mem[w][o] = v;
    endcase
  endtask

  function automatic logic [7:0] step(input logic [7:0] p);
    return {p[7:5], p[4:0] + 5'd1};
  endfunction

  task automatic clk_bit(input bit b, output bit seen);
    wt(8); m_sda = b;
    wt(8); scl = 1'b1;
    wt(8); seen = sda_bus;
    wt(8); scl = 1'b0;
  endtask

  task automatic bus_start();
    wt(8); m_sda = 1'b1;
    wt(8); scl = 1'b1;
    wt(8); m_sda = 1'b0;
    wt(8); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(8); m_sda = 1'b0;
    wt(8); scl = 1'b1;
    wt(8); m_sda = 1'b1;
    wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit nack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(nack, s);
  endtask

  task automatic probe(input logic [6:0] a, input bit exp_ack, input string tag);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    bus_stop();
  endtask

  task automatic do_wr(input logic [6:0] a, input logic [7:0] p,
                       input logic [7:0] d[$], input string tag);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack, "R1", int'(ack), 1);
    send_byte(p, ack);
    chk(ack, tag, int'(ack), 1);
    m_ptr = p;
    foreach (d[k]) begin
      send_byte(d[k], ack);
      chk(ack, tag, int'(ack), 1);
      ref_write(m_ptr, d[k]);
      m_ptr = step(m_ptr);
    end
    bus_stop();
  endtask

  task automatic do_rd(input logic [6:0] a, input logic [7:0] p,
                       input int n, input string tag);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({a, 1'b0}, ack);
    send_byte(p, ack);
    m_ptr = p;
    bus_start();
    send_byte({a, 1'b1}, ack);
    chk(ack, "R9", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(v, k == n - 1);
      chk(int'(v) == ref_read(m_ptr), tag, int'(v), ref_read(m_ptr));
      m_ptr = step(m_ptr);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] a;
    bit ack, s;
    logic [7:0] v;
    for (int p = 0; p < 5; p++)
      for (int o = 0; o < 32; o++) ref_mem[p][o] = 0;

    wt(5);
    chk(sda_oe == 1'b0, "R10", int'(sda_oe), 0);
    rst_n = 1'b1;
    wt(10);
    a = 7'h24;

    // R10: all pages zero after reset
    do_rd(a, 8'h00, 2, "R10");
    do_rd(a, 8'h7F, 1, "R10");
    do_rd(a, 8'hE5, 1, "R10");

    // R1: every strap combination
    for (int h = 0; h < 4; h++)
      for (int l = 0; l < 4; l++) begin
        strap_hi = 3'(h); strap_lo = 3'(l);
        wt(4);
        probe(7'(8'h18 + 8 * h + 2 * l), 1'b1, "R1");
        probe(7'(8'h19 + 8 * h + 2 * l), 1'b0, "R1");
      end

    // R2: reserved combinations
    strap_hi = 3'd4; strap_lo = 3'd0; wt(4);
    probe(7'h18, 1'b0, "R2");
    probe(7'h38, 1'b0, "R2");
    strap_hi = 3'd0; strap_lo = 3'd4; wt(4);
    probe(7'h18, 1'b0, "R2");
    probe(7'h20, 1'b0, "R2");

    strap_hi = 3'd1; strap_lo = 3'd2; wt(4);

    // R4: private pages
    do_wr(a, 8'h03, '{8'hA1, 8'hA2}, "R4");
    do_wr(a, 8'h23, '{8'hB1}, "R4");
    do_wr(a, 8'h43, '{8'hC1}, "R4");
    do_wr(a, 8'h63, '{8'hD1}, "R4");
    do_rd(a, 8'h03, 2, "R4");
    do_rd(a, 8'h23, 2, "R4");
    do_rd(a, 8'h43, 1, "R4");
    do_rd(a, 8'h63, 1, "R4");

    // R5: broadcast to all, then diverge channel 0 vs others
    do_wr(a, 8'h85, '{8'h55}, "R5");
    do_rd(a, 8'h05, 1, "R5");
    do_rd(a, 8'h25, 1, "R5");
    do_rd(a, 8'h45, 1, "R5");
    do_rd(a, 8'h65, 1, "R5");
    do_wr(a, 8'h25, '{8'h5A}, "R5");
    do_rd(a, 8'h85, 1, "R5");

    // R6: pair 0/1
    do_wr(a, 8'h46, '{8'h22}, "R6");
    do_wr(a, 8'hA6, '{8'h66}, "R6");
    do_wr(a, 8'h26, '{8'h77}, "R6");
    do_rd(a, 8'h06, 1, "R6");
    do_rd(a, 8'h26, 1, "R6");
    do_rd(a, 8'h46, 1, "R6");
    do_rd(a, 8'hA6, 1, "R6");

    // R7: pair 2/3
    do_wr(a, 8'hC7, '{8'h3C}, "R7");
    do_wr(a, 8'h67, '{8'h99}, "R7");
    do_rd(a, 8'h07, 1, "R7");
    do_rd(a, 8'h47, 1, "R7");
    do_rd(a, 8'h67, 1, "R7");
    do_rd(a, 8'hC7, 1, "R7");

    // R8: shared page
    do_wr(a, 8'hE8, '{8'hE1, 8'hE2}, "R8");
    do_rd(a, 8'hE8, 2, "R8");
    do_rd(a, 8'h08, 1, "R8");
    do_rd(a, 8'h68, 1, "R8");

    // R3: offset wrap keeps window
    do_wr(a, 8'h3E, '{8'h11, 8'h22, 8'h33}, "R3");
    do_rd(a, 8'h3E, 3, "R3");
    do_rd(a, 8'h20, 1, "R3");
    do_rd(a, 8'h40, 1, "R3");
    do_rd(a, 8'h00, 1, "R3");

    // R11: bytes after STOP are ignored
    do_wr(a, 8'h10, '{}, "R11");
    wt(8); scl = 1'b0;
    send_byte({a, 1'b0}, ack);
    chk(ack == 1'b0, "R11", int'(ack), 0);
    send_byte(8'h5E, ack);
    chk(ack == 1'b0, "R11", int'(ack), 0);
    bus_stop();
    do_rd(a, 8'h10, 1, "R11");

    // R12: host NACK releases the bus
    do_wr(a, 8'h03, '{}, "R12");
    bus_start();
    send_byte({a, 1'b1}, ack);
    chk(ack, "R12", int'(ack), 1);
    recv_byte(v, 1'b1);
    chk(int'(v) == ref_read(8'h03), "R12", int'(v), ref_read(8'h03));
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk(s == 1'b1, "R12", int'(s), 1);
    end
    bus_stop();

    // R10: reset mid-run clears pages
    wt(4); rst_n = 1'b0;
    wt(4);
    chk(sda_oe == 1'b0, "R10", int'(sda_oe), 0);
    rst_n = 1'b1;
    for (int p = 0; p < 5; p++)
      for (int o = 0; o < 32; o++) ref_mem[p][o] = 0;
    wt(8);
    do_rd(a, 8'h03, 2, "R10");
    do_rd(a, 8'h63, 1, "R10");
    do_rd(a, 8'hE8, 1, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule